// File: doc/BRIEF.md
# DMA Interrupt Control Register

This block is the 32-bit interrupt control register that sits beside a multi-channel DMA engine. Each channel's completion pulse is latched into a per-channel flag, but only if software has enabled that channel. Software clears a flag by writing a 1 to its bit. A master flag combines the master enable, the latched flags and a bus-error bit into a single summary. When that summary goes from clear to set, the block emits a one-cycle pulse. The main interrupt controller uses this pulse to set its DMA status bit. Writing a 0 to a flag bit leaves that flag unchanged, so software can update enables without losing pending completions.

The master flag is held by a two-state machine.
- `ST_CLEAR` means no summary interrupt is pending.
- `ST_RAISED` means the summary interrupt is pending.
- The transition `CLEAR->RAISED` (named *fire*) emits the pulse.
- `RAISED->CLEAR` (named *drop*) happens when every raise condition has gone away.
- The self-loops *hold-clear* and *hold-raised* emit nothing.

The next state is evaluated from the register contents that result from the current cycle's write and completion events. Every register change is therefore visible on the next cycle, together with any pulse it causes.

Register layout:

| Bits | Field |
|------|-------|
| [5:0] | Plain storage |
| [15] | Bus-error force |
| [22:16] | Per-channel enables |
| [23] | Master enable |
| [30:24] | Per-channel flags |
| [31] | Master flag |

Bits [14:6] always read zero.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After reset, `rd_data` is 0x00000000 and `irq_pulse` is low, and reset itself produces no pulse.
- R2: A write stores exactly the written bits selected by mask 0x00ff803f (bits [5:0], 15 and [23:16]); bits [14:6] always read 0.
- R3: Bit 31 cannot be written: writing a 1 there has no effect on the read value when the raise condition of R6 is false.
- R4: A write with 1 in bit 24+n clears flag n; a write with 0 in bit 24+n leaves flag n unchanged.
- R5: A pulse on `done_pulse[n]` sets flag bit 24+n only if enable bit 16+n was already set before that cycle; otherwise the flag is unaffected.
- R6: Bit 31 equals (bit 23 AND any of bits [30:24]) OR bit 15. It is recomputed, with one cycle of latency, after every write, completion or bus-error event.
- R7: `irq_pulse` is high for exactly one cycle, in the same cycle bit 31 first reads 1 after having read 0. No pulse occurs while bit 31 stays set.
- R8: A cycle with `bus_err` high sets bit 15 (so bit 31 rises); bit 15 stays set until a write with 0 in bit 15.
- R9: If a write acknowledging flag n and an enabled completion pulse on channel n occur in the same cycle, flag n ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_data | input | 32 | Write value |
| done_pulse | input | NUM_CH | Per-channel completion pulses |
| bus_err | input | 1 | Bus-error event, sets bit 15 |
| rd_data | output | 32 | Current register value |
| irq_pulse | output | 1 | One-cycle upstream interrupt request |

## Verification
The assertions assume that the completion and bus-error inputs are synchronous to `clk`. They also assume that a cycle with `wr_en` high carries a complete 32-bit value; there are no byte enables. The directed stimulus changes every input only on the falling edge. It holds each pulse input high for exactly one cycle. It writes whole words, including deliberate 1s in the reserved bits and in bit 31, so that the masking rules are exercised while staying within these assumptions.

// File: rtl/dma_icr_pkg.sv
package dma_icr_pkg;
    localparam int REG_W     = 32;
    localparam int LOW_W     = 6;
    localparam int BERR_BIT  = 15;
    localparam int EN_LSB    = 16;
    localparam int MEN_BIT   = 23;
    localparam int FLAG_LSB  = 24;
    localparam int MFLAG_BIT = 31;
    localparam int MAX_CH    = MEN_BIT - EN_LSB;

    typedef enum logic {
        ST_CLEAR  = 1'b0,
        ST_RAISED = 1'b1
    } icr_state_e;
endpackage

// File: rtl/dma_icr_fields.sv
module dma_icr_fields
    import dma_icr_pkg::*;
#(
    parameter int NUM_CH = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [NUM_CH-1:0] done_pulse,
    input  logic              bus_err,
    output logic [LOW_W-1:0]  low_q,
    output logic              berr_q,
    output logic [NUM_CH-1:0] en_q,
    output logic              men_q,
    output logic [NUM_CH-1:0] flag_q,
    output logic              raise_cond
);
    logic [LOW_W-1:0]  low_d;
    logic              berr_d;
    logic [NUM_CH-1:0] en_d;
    logic              men_d;
    logic [NUM_CH-1:0] flag_d;
    logic [NUM_CH-1:0] kept;
    logic [NUM_CH-1:0] latched;
    logic              unused_wr_bits;

    assign unused_wr_bits = ^{wr_data[BERR_BIT-1:LOW_W], wr_data[MFLAG_BIT]};

    // Completion events use the enables held before this cycle.
    assign latched = done_pulse & en_q;
    assign kept    = wr_en ? (flag_q & ~wr_data[FLAG_LSB +: NUM_CH]) : flag_q;

    always_comb begin
        low_d  = wr_en ? wr_data[LOW_W-1:0]        : low_q;
        berr_d = (wr_en ? wr_data[BERR_BIT] : berr_q) | bus_err;
        en_d   = wr_en ? wr_data[EN_LSB +: NUM_CH] : en_q;
        men_d  = wr_en ? wr_data[MEN_BIT]          : men_q;
        flag_d = kept | latched;
    end

    // Summary condition from the post-update contents.
    assign raise_cond = (men_d && (|flag_d)) || berr_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_q  <= '0;
            berr_q <= 1'b0;
            en_q   <= '0;
            men_q  <= 1'b0;
            flag_q <= '0;
        end else begin
            low_q  <= low_d;
            berr_q <= berr_d;
            en_q   <= en_d;
            men_q  <= men_d;
            flag_q <= flag_d;
        end
    end

    for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
        p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en && wr_data[FLAG_LSB+n] && !done_pulse[n] |=> !flag_q[n]);
        p_zero_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
            flag_q[n] && !(wr_en && wr_data[FLAG_LSB+n]) |=> flag_q[n]);
        p_masked_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !en_q[n] && !flag_q[n] |=> !flag_q[n]);
        p_done_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
            done_pulse[n] && en_q[n] |=> flag_q[n]);
    end

    p_berr_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |=> berr_q);
endmodule

// File: rtl/dma_icr_master_fsm.sv
module dma_icr_master_fsm
    import dma_icr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raise_cond,
    output logic master_q,
    output logic irq_pulse
);
    icr_state_e state_q, state_d;
    logic       fire;

    always_comb begin
        state_d = state_q;
        fire    = 1'b0;
        unique case (state_q)
            ST_CLEAR: begin
                if (raise_cond) begin
                    state_d = ST_RAISED;
                    fire    = 1'b1;
                end
            end
            ST_RAISED: begin
                if (!raise_cond) begin
                    state_d = ST_CLEAR;
                end
            end
            default: state_d = ST_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_pulse <= 1'b0;
        end else begin
            irq_pulse <= fire;
        end
    end

    assign master_q = (state_q == ST_RAISED);

    p_pulse_on_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> master_q && !$past(master_q));
    p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);
    p_rise_pulses_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(master_q) |-> irq_pulse);
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
    import dma_icr_pkg::*;
#(
    parameter int NUM_CH = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    input  logic [NUM_CH-1:0] done_pulse,
    input  logic              bus_err,
    output logic [31:0]       rd_data,
    output logic              irq_pulse
);
    logic [LOW_W-1:0]  low_q;
    logic              berr_q;
    logic [NUM_CH-1:0] en_q;
    logic              men_q;
    logic [NUM_CH-1:0] flag_q;
    logic              raise_cond;
    logic              master_q;

    initial begin
        a_ch_count: assert (NUM_CH >= 1 && NUM_CH <= MAX_CH);
    end

    dma_icr_fields #(.NUM_CH(NUM_CH)) u_fields (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .done_pulse (done_pulse),
        .bus_err    (bus_err),
        .low_q      (low_q),
        .berr_q     (berr_q),
        .en_q       (en_q),
        .men_q      (men_q),
        .flag_q     (flag_q),
        .raise_cond (raise_cond)
    );

    dma_icr_master_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .raise_cond (raise_cond),
        .master_q   (master_q),
        .irq_pulse  (irq_pulse)
    );

    always_comb begin
        rd_data                     = '0;
        rd_data[LOW_W-1:0]          = low_q;
        rd_data[BERR_BIT]           = berr_q;
        rd_data[EN_LSB +: NUM_CH]   = en_q;
        rd_data[MEN_BIT]            = men_q;
        rd_data[FLAG_LSB +: NUM_CH] = flag_q;
        rd_data[MFLAG_BIT]          = master_q;
    end

    p_master_rule_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[MFLAG_BIT] == ((rd_data[MEN_BIT] && (|rd_data[30:FLAG_LSB])) || rd_data[BERR_BIT]));
    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[BERR_BIT-1:LOW_W] == '0);
endmodule

// File: tb/sim_dma_irq_ctrl.sv
module sim_dma_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [6:0]  done_pulse = '0;
    logic        bus_err = 1'b0;
    logic [31:0] rd_data;
    logic        irq_pulse;
    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    dma_irq_ctrl #(.NUM_CH(7)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .done_pulse(done_pulse), .bus_err(bus_err),
        .rd_data(rd_data), .irq_pulse(irq_pulse)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // One cycle of stimulus; results are sampled 1 ns after the edge.
    task automatic step(input logic we, input logic [31:0] d, input logic [6:0] dn, input logic be);
        @(negedge clk);
        wr_en = we; wr_data = d; done_pulse = dn; bus_err = be;
        @(posedge clk);
        #1;
        wr_en = 1'b0; wr_data = '0; done_pulse = '0; bus_err = 1'b0;
    endtask

    task automatic t_reset;
        #1;
        chk("R1 reset value", rd_data, 32'h0);
        chk("R1 no pulse in reset", {31'h0, irq_pulse}, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        step(1'b0, 0, 0, 1'b0);
        chk("R1 value after release", rd_data, 32'h0);
        chk("R1 no pulse after release", {31'h0, irq_pulse}, 32'h0);
    endtask

    task automatic t_write_mask;
        step(1'b1, 32'h7F7F_7FFF, 0, 1'b0);
        chk("R2 masked store", rd_data, 32'h007F_003F);
        step(1'b1, 32'h8000_0000, 0, 1'b0);
        chk("R3 bit31 not writable", rd_data, 32'h0);
        chk("R3 no pulse", {31'h0, irq_pulse}, 32'h0);
    endtask

    task automatic t_enables;
        step(1'b0, 0, 7'h04, 1'b0);
        chk("R5 disabled channel ignored", rd_data, 32'h0);
        step(1'b1, 32'h007F_0000, 0, 1'b0);
        step(1'b0, 0, 7'h41, 1'b0);
        chk("R5 enabled flags set, R6 no master", rd_data, 32'h417F_0000);
        chk("R6 no pulse without master enable", {31'h0, irq_pulse}, 32'h0);
    endtask

    task automatic t_master;
        step(1'b1, 32'h00FF_0000, 0, 1'b0);
        chk("R6 master set by enable", rd_data, 32'hC1FF_0000);
        chk("R7 pulse on rise", {31'h0, irq_pulse}, 32'h1);
        step(1'b0, 0, 7'h08, 1'b0);
        chk("R7 pulse lasts one cycle", {31'h0, irq_pulse}, 32'h0);
        chk("R5 extra flag while raised", rd_data, 32'hC9FF_0000);
    endtask

    task automatic t_ack;
        step(1'b1, 32'h41FF_0000, 0, 1'b0);
        chk("R4 partial ack", rd_data, 32'h88FF_0000);
        chk("R7 no pulse while raised", {31'h0, irq_pulse}, 32'h0);
        step(1'b1, 32'h08FF_0000, 0, 1'b0);
        chk("R6 master drops on last ack", rd_data, 32'h00FF_0000);
        step(1'b0, 0, 7'h02, 1'b0);
        chk("R7 re-raise value", rd_data, 32'h82FF_0000);
        chk("R7 re-raise pulse", {31'h0, irq_pulse}, 32'h1);
    endtask

    task automatic t_same_cycle;
        step(1'b1, 32'h02FF_0000, 7'h02, 1'b0);
        chk("R9 completion beats ack", rd_data, 32'h82FF_0000);
        chk("R9 no pulse", {31'h0, irq_pulse}, 32'h0);
        step(1'b1, 32'h0200_0000, 0, 1'b0);
        chk("R4 cleanup", rd_data, 32'h0);
    endtask

    task automatic t_bus_error;
        step(1'b0, 0, 0, 1'b1);
        chk("R8 bus error sets bit15", rd_data, 32'h8000_8000);
        chk("R8 bus error pulse", {31'h0, irq_pulse}, 32'h1);
        step(1'b0, 0, 0, 1'b0);
        chk("R8 bit15 sticky", rd_data, 32'h8000_8000);
        step(1'b1, 32'h0000_0000, 0, 1'b0);
        chk("R8 cleared by write", rd_data, 32'h0);
        step(1'b1, 32'h0000_8000, 0, 1'b0);
        chk("R8 forced by write", rd_data, 32'h8000_8000);
        chk("R7 pulse on forced rise", {31'h0, irq_pulse}, 32'h1);
        step(1'b1, 32'h0, 0, 1'b0);
        chk("R6 drop after force off", rd_data, 32'h0);
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog actual=%08h expected=%08h", 32'h1, 32'h0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_write_mask();
        t_enables();
        t_master();
        t_ack();
        t_same_cycle();
        t_bus_error();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule